// File: doc/BRIEF.md
# Power-Supply Supervisor Fault Latch and Power-Good Timer

This block is the digital timing core of a supply supervisor for a PC power supply. External comparators turn the rail voltages into flags before they reach it: over-voltage on the 3.3 V, 5 V and 12 V rails, and under-voltage on the 3.3 V and 5 V rails. The block also takes a power-good input and an active-low protection-enable input. Each comparator flag must hold a new level for a set number of cycles before the block accepts it. The enable input gets a much longer settling filter. A qualified fault sets a sticky latch, and only a debounced rising edge on the enable input clears it, after a programmed delay.

Under-voltage flags are blanked for a fixed window after the enable becomes active, which is the supply turning on. Over-voltage is honoured at all times. Power-good is granted after a long qualification delay with every condition met. It is withdrawn at once when a condition drops. Both outputs are pull-down enables for open-drain pins with external pull-ups. All time constants are parameters counted in clock cycles.

Top module: `psu_guard_core`

## Requirements
- R1: A synchronous active-high reset clears the latch, zeroes every timer and drives both pull-down enables to 1. For the fault pin, 1 means no fault latched and 0 means latched. For the power-good pin, 1 means not good.
- R2: An over-voltage flag held at 1 for GLITCH_CYC cycles on any rail latches a fault. ov_flag_i bit 0 is 3.3 V, bit 1 is 5 V and bit 2 is 12 V. The filtered flag changes at the GLITCH_CYC-th rising edge after the raw change. fault_pull_low_o falls one edge later.
- R3: A flag pulse lasting GLITCH_CYC-1 cycles or fewer has no effect on either output.
- R4: An under-voltage flag latches a fault only while the under-voltage window is armed. uv_flag_i bit 0 is 3.3 V and bit 1 is 5 V. The window arms UV_BLANK_CYC edges after the debounced enable goes low. Over-voltage latches whether or not the block is enabled.
- R5: prot_en_n_i must hold a new level for DEBOUNCE_CYC cycles before the block acts on it. A shorter excursion does not release a latched fault.
- R6: Removing the fault flags never clears the latch. The latch clears RELEASE_CYC edges after the debounced enable rises, so fault_pull_low_o returns to 1 at edge DEBOUNCE_CYC+RELEASE_CYC after prot_en_n_i rises.
- R7: pgood_pull_low_o falls to 0 at the PG_CYC-th edge after these all hold: pg_in_i high, no filtered flag set, and no fault latched. Any dropout restarts the count from zero.
- R8: Power-good deasserts in the same cycle pg_in_i falls. It also deasserts no later than the edge at which a flag is accepted or a fault latches.
- R9: Deasserting the enable disarms the under-voltage window. An under-voltage flag while disabled is ignored, and the blanking restarts on the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ov_flag_i | input | 3 | Over-voltage comparator flags (bit0 3.3 V, bit1 5 V, bit2 12 V) |
| uv_flag_i | input | 2 | Under-voltage comparator flags (bit0 3.3 V, bit1 5 V) |
| pg_in_i | input | 1 | Power-good input, high when the upstream supply is good |
| prot_en_n_i | input | 1 | Protection enable, active low |
| fault_pull_low_o | output | 1 | Pull-down enable of the fault pin; 0 lets the pin rise (fault latched) |
| pgood_pull_low_o | output | 1 | Pull-down enable of the power-good pin; 0 means power good |

## Verification
Any state error in this block shows up at one of the two pins, but sometimes only after a long delay. A filter that accepts early or late moves the fault pin's fall by whole cycles, so the bench samples the exact edge on both sides of it. A blanking or release counter that is off by one moves the latch set or release edge, and this is only visible when the bench counts edges from the enable change. A latch that clears without an enable edge, or a power-good counter that does not restart, may go unseen until a later scenario, so each scenario checks the pins again before it hands over.

// File: rtl/psu_guard_pkg.sv
package psu_guard_pkg;

   localparam int unsigned OV_RAILS = 3;
   localparam int unsigned UV_RAILS = 2;

   localparam int unsigned RAIL_3V3 = 0;
   localparam int unsigned RAIL_5V0 = 1;
   localparam int unsigned RAIL_12V = 2;

   typedef logic [OV_RAILS-1:0] ov_vec_t;
   typedef logic [UV_RAILS-1:0] uv_vec_t;

   typedef enum logic [1:0] {
      TMR_IDLE = 2'd0,
      TMR_RUN  = 2'd1,
      TMR_DONE = 2'd2
   } tmr_phase_e;

endpackage

// File: rtl/psu_guard_stable.sv
module psu_guard_stable #(
   parameter int unsigned CYC     = 4,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_i,
   output logic stable_o
);

   generate
      if (CYC < 1) begin : g_bad
         $error("psu_guard_stable: CYC must be at least 1");
      end

      if (CYC <= 1) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) stable_o <= RST_VAL;
            else     stable_o <= raw_i;
         end
      end else begin : g_cnt
         localparam int unsigned W = $clog2(CYC);
         logic [W-1:0] run_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               stable_o <= RST_VAL;
               run_q    <= '0;
            end else if (raw_i == stable_o) begin
               run_q <= '0;
            end else if (run_q == W'(CYC - 1)) begin
               stable_o <= raw_i;
               run_q    <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         // R3: an accepted level equals what the raw input held, after a full run
         p_accept_full_run_r3: assert property (@(posedge clk) disable iff (rst)
            (stable_o != $past(stable_o)) |-> (stable_o == $past(raw_i)) && ($past(run_q) == W'(CYC - 1)));
      end
   endgenerate

endmodule

// File: rtl/psu_guard_window.sv
module psu_guard_window #(
   parameter int unsigned CYC = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   output logic hit_o,
   output logic done_o
);

   localparam int unsigned W = (CYC < 1) ? 1 : $clog2(CYC + 1);

   generate
      if (CYC < 1) begin : g_bad
         $error("psu_guard_window: CYC must be at least 1");
      end
   endgenerate

   import psu_guard_pkg::*;

   logic [W-1:0] cnt_q;
   tmr_phase_e   phase;

   always_ff @(posedge clk) begin
      if (rst || !run_i)          cnt_q <= '0;
      else if (cnt_q != W'(CYC))  cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      if (cnt_q == '0)             phase = TMR_IDLE;
      else if (cnt_q == W'(CYC))   phase = TMR_DONE;
      else                         phase = TMR_RUN;
   end

   assign done_o = (phase == TMR_DONE);
   assign hit_o  = run_i && (cnt_q == W'(CYC - 1));

   // R7: the window counter saturates and never passes its limit
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= W'(CYC));

   // R7: a stalled run always restarts from zero
   p_restart_r7: assert property (@(posedge clk) disable iff (rst)
      !$past(run_i) |-> (cnt_q == '0));

endmodule

// File: rtl/psu_guard_latch.sv
module psu_guard_latch
   import psu_guard_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  ov_vec_t ov_flt_i,
   input  uv_vec_t uv_flt_i,
   input  logic    uv_armed_i,
   input  logic    release_hit_i,
   output logic    latched_o
);

   logic ov_any;
   logic uv_any;
   logic fault_now;

   assign ov_any    = |ov_flt_i;
   assign uv_any    = |uv_flt_i;
   assign fault_now = ov_any || (uv_any && uv_armed_i);

   always_ff @(posedge clk) begin
      if (rst)                latched_o <= 1'b0;
      else if (fault_now)     latched_o <= 1'b1;
      else if (release_hit_i) latched_o <= 1'b0;
   end

   // R4: without over-voltage, a new latch needs the armed under-voltage window
   p_uv_gated_r4: assert property (@(posedge clk) disable iff (rst)
      ($rose(latched_o) && !$past(|ov_flt_i)) |-> $past(uv_armed_i && (|uv_flt_i)));

   // R6: the latch only clears on the release timer
   p_release_only_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(latched_o) |-> $past(release_hit_i));

endmodule

// File: rtl/psu_guard_core.sv
module psu_guard_core
   import psu_guard_pkg::*;
#(
   parameter int unsigned CLK_KHZ      = 1000,
   parameter int unsigned GLITCH_CYC   = (73 * CLK_KHZ + 999) / 1000,
   parameter int unsigned DEBOUNCE_CYC = 38 * CLK_KHZ,
   parameter int unsigned UV_BLANK_CYC = 75 * CLK_KHZ,
   parameter int unsigned PG_CYC       = 300 * CLK_KHZ,
   parameter int unsigned RELEASE_CYC  = (24 * CLK_KHZ + 9) / 10
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [2:0] ov_flag_i,
   input  logic [1:0] uv_flag_i,
   input  logic       pg_in_i,
   input  logic       prot_en_n_i,
   output logic       fault_pull_low_o,
   output logic       pgood_pull_low_o
);

   generate
      if (CLK_KHZ < 1) begin : g_bad_clk
         $error("psu_guard_core: CLK_KHZ must be positive");
      end
      if (DEBOUNCE_CYC <= GLITCH_CYC) begin : g_bad_order
         $error("psu_guard_core: enable debounce must exceed flag deglitch");
      end
   endgenerate

   ov_vec_t ov_flt;
   uv_vec_t uv_flt;
   logic    en_n_db;
   logic    uv_armed;
   logic    blank_hit;
   logic    rel_hit;
   logic    rel_done;
   logic    latched;
   logic    pg_cond;
   logic    pg_done;
   logic    pg_hit;
   logic    unused_win;

   // Flag deglitch, one filter per rail
   generate
      for (genvar i = 0; i < OV_RAILS; i++) begin : g_ov
         psu_guard_stable #(.CYC(GLITCH_CYC), .RST_VAL(1'b0)) u_flt (
            .clk(clk), .rst(rst), .raw_i(ov_flag_i[i]), .stable_o(ov_flt[i]));
      end
      for (genvar j = 0; j < UV_RAILS; j++) begin : g_uv
         psu_guard_stable #(.CYC(GLITCH_CYC), .RST_VAL(1'b0)) u_flt (
            .clk(clk), .rst(rst), .raw_i(uv_flag_i[j]), .stable_o(uv_flt[j]));
      end
   endgenerate

   // Enable debounce, resting disabled
   psu_guard_stable #(.CYC(DEBOUNCE_CYC), .RST_VAL(1'b1)) u_en_db (
      .clk(clk), .rst(rst), .raw_i(prot_en_n_i), .stable_o(en_n_db));

   // Under-voltage blanking after enable
   psu_guard_window #(.CYC(UV_BLANK_CYC)) u_blank (
      .clk(clk), .rst(rst), .run_i(!en_n_db), .hit_o(blank_hit), .done_o(uv_armed));

   // Delayed latch release after the enable rises
   psu_guard_window #(.CYC(RELEASE_CYC)) u_release (
      .clk(clk), .rst(rst), .run_i(en_n_db), .hit_o(rel_hit), .done_o(rel_done));

   psu_guard_latch u_latch (
      .clk(clk), .rst(rst),
      .ov_flt_i(ov_flt), .uv_flt_i(uv_flt),
      .uv_armed_i(uv_armed), .release_hit_i(rel_hit),
      .latched_o(latched));

   // Power-good qualification
   assign pg_cond = pg_in_i && !latched && (ov_flt == '0) && (uv_flt == '0);

   psu_guard_window #(.CYC(PG_CYC)) u_pgood (
      .clk(clk), .rst(rst), .run_i(pg_cond), .hit_o(pg_hit), .done_o(pg_done));

   assign unused_win = ^{blank_hit, rel_done, pg_hit};

   assign fault_pull_low_o = !latched;
   assign pgood_pull_low_o = !(pg_done && pg_cond);

   // R8: a latched fault never coexists with power good
   p_pg_off_latched_r8: assert property (@(posedge clk) disable iff (rst)
      !fault_pull_low_o |-> pgood_pull_low_o);

   // R6: release only happens with the debounced enable high
   p_release_enabled_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(fault_pull_low_o) |-> $past(en_n_db));

   // R9: the under-voltage window is never armed while disabled
   p_disarm_r9: assert property (@(posedge clk) disable iff (rst)
      $past(en_n_db) |-> !uv_armed);

   // R7: power good only rises after the input has been high
   p_pg_needs_input_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(pgood_pull_low_o) |-> $past(pg_in_i));

endmodule

// File: tb/psu_guard_core_tb_top.sv
module psu_guard_core_tb_top;

   localparam int unsigned NG = 4;
   localparam int unsigned ND = 8;
   localparam int unsigned NB = 20;
   localparam int unsigned NP = 30;
   localparam int unsigned NR = 6;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] ov  = '0;
   logic [1:0] uv  = '0;
   logic       pg  = 1'b0;
   logic       en_n = 1'b1;
   logic       fault_pl;
   logic       pgood_pl;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   psu_guard_core #(
      .CLK_KHZ(1), .GLITCH_CYC(NG), .DEBOUNCE_CYC(ND),
      .UV_BLANK_CYC(NB), .PG_CYC(NP), .RELEASE_CYC(NR)
   ) dut_i (
      .clk(clk), .rst(rst), .ov_flag_i(ov), .uv_flag_i(uv),
      .pg_in_i(pg), .prot_en_n_i(en_n),
      .fault_pull_low_o(fault_pl), .pgood_pull_low_o(pgood_pl));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic power_on();
      en_n = 1'b0;
      tick(ND + NB + 2);
   endtask

   task automatic t_reset();
      tick(1);
      chk("R1", "fault pin after reset", fault_pl, 1'b1);
      chk("R1", "pgood pin after reset", pgood_pl, 1'b1);
      rst = 1'b0;
      tick(1);
      chk("R1", "fault pin idle", fault_pl, 1'b1);
   endtask

   task automatic t_pgood();
      pg = 1'b1;
      tick(NP - 1);
      chk("R7", "pgood one edge early", pgood_pl, 1'b1);
      tick(1);
      chk("R7", "pgood at delay", pgood_pl, 1'b0);
      pg = 1'b0;
      #1;
      chk("R8", "pgood drops with input", pgood_pl, 1'b1);
      pg = 1'b1;
      tick(NP / 2);
      pg = 1'b0;
      tick(1);
      pg = 1'b1;
      tick(NP - 1);
      chk("R7", "restarted count not done", pgood_pl, 1'b1);
      tick(1);
      chk("R7", "restarted count done", pgood_pl, 1'b0);
   endtask

   task automatic t_glitch();
      ov[2] = 1'b1;
      tick(NG - 1);
      ov[2] = 1'b0;
      tick(NG + 2);
      chk("R3", "short ov pulse fault", fault_pl, 1'b1);
      chk("R3", "short ov pulse pgood", pgood_pl, 1'b0);
      uv[1] = 1'b1;
      tick(NG - 1);
      uv[1] = 1'b0;
      tick(NG + 2);
      chk("R3", "short uv pulse fault", fault_pl, 1'b1);
      chk("R3", "short uv pulse pgood", pgood_pl, 1'b0);
   endtask

   task automatic t_ov_rail(input int r);
      ov[r] = 1'b1;
      tick(NG - 1);
      chk("R2", "pgood before accept", pgood_pl, 1'b0);
      tick(1);
      chk("R8", "pgood off at accept", pgood_pl, 1'b1);
      chk("R2", "fault not yet latched", fault_pl, 1'b1);
      tick(1);
      chk("R2", "fault latched", fault_pl, 1'b0);
      ov[r] = 1'b0;
      tick(NG + 3);
      chk("R6", "latch holds with flags gone", fault_pl, 1'b0);
      chk("R8", "pgood off while latched", pgood_pl, 1'b1);
      en_n = 1'b1;
      tick(ND - 1);
      en_n = 1'b0;
      tick(ND + NR + 3);
      chk("R5", "short enable pulse ignored", fault_pl, 1'b0);
      en_n = 1'b1;
      tick(ND + NR - 1);
      chk("R6", "release one edge early", fault_pl, 1'b0);
      tick(1);
      chk("R6", "release at delay", fault_pl, 1'b1);
      power_on();
      tick(NP);
      chk("R7", "pgood recovered", pgood_pl, 1'b0);
   endtask

   task automatic t_uv();
      en_n = 1'b1;
      tick(ND + 2);
      uv[0] = 1'b1;
      tick(NG + 3);
      chk("R9", "uv while disabled", fault_pl, 1'b1);
      chk("R7", "uv flag blocks pgood", pgood_pl, 1'b1);
      en_n = 1'b0;
      tick(ND + NB);
      chk("R4", "uv blanked to window end", fault_pl, 1'b1);
      tick(1);
      chk("R4", "uv latches once armed", fault_pl, 1'b0);
      uv[0] = 1'b0;
      en_n = 1'b1;
      tick(ND + NR - 1);
      chk("R6", "uv release early", fault_pl, 1'b0);
      tick(1);
      chk("R6", "uv release at delay", fault_pl, 1'b1);
      ov[1] = 1'b1;
      tick(NG + 1);
      chk("R4", "ov latches while disabled", fault_pl, 1'b0);
      ov[1] = 1'b0;
      tick(NG + 1);
      en_n = 1'b0;
      tick(ND + 2);
      en_n = 1'b1;
      tick(ND + NR + 1);
      chk("R6", "release after fresh rise", fault_pl, 1'b1);
      power_on();
      uv[1] = 1'b1;
      tick(NG + 1);
      chk("R4", "uv on 5V rail latches", fault_pl, 1'b0);
      uv[1] = 1'b0;
      en_n = 1'b1;
      tick(ND + NR + 1);
      chk("R6", "final release", fault_pl, 1'b1);
      power_on();
   endtask

   initial begin
      tick(3);
      t_reset();
      power_on();
      chk("R4", "no fault after enable", fault_pl, 1'b1);
      t_pgood();
      t_glitch();
      for (int r = 0; r < 3; r++) t_ov_rail(r);
      t_uv();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule